// File: doc/BRIEF.md
# Variable-Length Instruction Stream Parser

This block sits between an instruction fetch byte stream and a decoder for a RISC-style machine with 32-bit registers and byte addressing. Bytes arrive one per handshake. The parser reads the length code from the first byte of each instruction and collects the rest of that instruction. It then checks whether the second-operand field asks for trailing immediate bytes, and if so collects those as well. When the instruction and its immediate are complete, it presents one decoded record and holds it until the consumer takes it.

The record carries the primary opcode, the length code, three 5-bit register fields, the immediate-select flag, a 32-bit immediate rebuilt from the inline constant or the trailing bytes, and the extension fields of the longer formats. It also carries the total number of bytes used, so a fetch unit can advance its program counter by that amount. A flush input discards any work in progress, including a record that has not yet been taken.

Top module: `vlp_parser`

## Requirements
- R1: After reset, or in the cycle after a flush, `in_ready` is 1 and `out_valid` is 0.
- R2: First byte bits [7:6] are a length code. 0, 1, 2 and 3 select an instruction of 3, 4, 5 and 6 bytes. Bits [5:0] are reported as the opcode.
- R3: With bytes 1 and 2 read as the little-endian halfword {byte2, byte1}: bits [4:0] are the destination register, [9:5] the first source, [14:10] the second-operand field, and bit 15 the immediate-select flag.
- R4: Byte 3 is reported as the 8-bit invert mask. In byte 4, bits [4:0] are the predicate and bit 5 is the status-update enable. The spare output is {byte5, byte4[7:6]}. Any of these bytes that is absent from a shorter instruction reads as zero.
- R5: If the immediate flag is 1 and field bit 4 is 0, the immediate is field[3:0] zero-extended, and no trailing bytes are consumed.
- R6: If the immediate flag is 1 and field[4:3] is 10, exactly one trailing byte follows. The immediate is {field[2:0], byte}, sign-extended from 11 bits.
- R7: If the immediate flag is 1 and field[4:3] is 11, field[2:0]+1 trailing bytes follow in little-endian order. The low four bytes are kept, and a value of fewer than four bytes is sign-extended from its top byte.
- R8: If the immediate flag is 0, the immediate is zero, no trailing bytes are consumed, and the field is reported unchanged as a register number.
- R9: `out_nbytes` equals the instruction length plus the number of trailing immediate bytes, between 3 and 14.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record does not change and `in_ready` is 0. A byte offered during that time is taken after release, and none is lost or repeated.
- R11: A flush in any state discards the partial instruction or pending record. The next byte accepted is treated as the first byte of a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard partial work and any pending record |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Parser can take a byte |
| in_data | input | 8 | Stream byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 6 | Primary opcode |
| out_len_code | output | 2 | Length code |
| out_rd | output | 5 | Destination register |
| out_rs1 | output | 5 | First source register |
| out_src2 | output | 5 | Second-operand field |
| out_imm_sel | output | 1 | Immediate-select flag |
| out_invert | output | 8 | Operand invert mask |
| out_upd | output | 1 | Status-update enable |
| out_pred | output | 5 | Predicate condition |
| out_spare | output | 10 | Reserved extension bits |
| out_imm | output | 32 | Rebuilt immediate |
| out_nbytes | output | 4 | Total bytes consumed |

## Verification
The hardest cases to reach are the two places where the phases meet. In one, a 3-byte instruction has its immediate selector in its final byte, so the trailing-byte count has to be taken from the incoming byte rather than from a stored one. In the other, a new instruction's first byte is already offered while the previous record is still held. Directed tasks build both cases on purpose: every length code with every immediate mode, including trailing runs of 1 to 8 bytes, and a held record with the next byte waiting on the input. A seeded random mix with random hold lengths and flushes placed in each phase then compares every record against a bench model written from the requirements.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAX_INSN  = 6;
    localparam int IMM_KEEP  = 4;
    localparam int REG_W     = 5;
    localparam int OPC_W     = 6;
    localparam int IMM_W     = IMM_KEEP * BYTE_W;
    localparam int CNT_W     = $clog2(MAX_INSN + 1);
    localparam int TRAIL_W   = 4;
    localparam int NBYTES_W  = 4;

    typedef enum logic [1:0] {
        S_INSN = 2'd0,
        S_IMM  = 2'd1,
        S_HOLD = 2'd2
    } vlp_state_e;

    typedef struct packed {
        logic [OPC_W-1:0]    opcode;
        logic [1:0]          len_code;
        logic [REG_W-1:0]    rd;
        logic [REG_W-1:0]    rs1;
        logic [REG_W-1:0]    src2;
        logic                imm_sel;
        logic [7:0]          invert;
        logic                upd;
        logic [4:0]          pred;
        logic [9:0]          spare;
        logic [IMM_W-1:0]    imm;
        logic [NBYTES_W-1:0] nbytes;
    } vlp_rec_t;

    // Bytes in the instruction proper, from the 2-bit length code.
    function automatic logic [CNT_W-1:0] insn_bytes(input logic [1:0] code);
        return CNT_W'({1'b0, code}) + CNT_W'(3);
    endfunction

    // Trailing immediate byte count from the byte holding flag and field.
    function automatic logic [TRAIL_W-1:0] trail_count(input logic [7:0] b2);
        logic [4:0] f;
        f = b2[6:2];
        if (!b2[7] || !f[4])
            return '0;
        else if (!f[3])
            return TRAIL_W'(1);
        else
            return TRAIL_W'({1'b0, f[2:0]}) + TRAIL_W'(1);
    endfunction

endpackage

// File: rtl/vlp_byte_gather.sv
module vlp_byte_gather #(
    parameter int DEPTH = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            din,
    output logic [DEPTH-1:0][7:0] q
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr)
                q[i] <= '0;
            else if (we && idx == IDX_W'(i))
                q[i] <= din;
        end
    end

endmodule

// File: rtl/vlp_imm_unit.sv
module vlp_imm_unit
    import vlp_pkg::*;
(
    input  logic                     imm_sel,
    input  logic [REG_W-1:0]         field,
    input  logic [IMM_KEEP-1:0][7:0] tb,
    output logic [IMM_W-1:0]         imm
);

    logic [2:0] nsel;
    assign nsel = field[2:0];

    always_comb begin
        imm = '0;
        if (imm_sel) begin
            if (!field[4]) begin
                imm = IMM_W'(field[3:0]);
            end else if (!field[3]) begin
                imm = {{(IMM_W-11){field[2]}}, field[2:0], tb[0]};
            end else begin
                case (nsel)
                    3'd0:    imm = {{(IMM_W-8){tb[0][7]}}, tb[0]};
                    3'd1:    imm = {{(IMM_W-16){tb[1][7]}}, tb[1], tb[0]};
                    3'd2:    imm = {{(IMM_W-24){tb[2][7]}}, tb[2], tb[1], tb[0]};
                    default: imm = {tb[3], tb[2], tb[1], tb[0]};
                endcase
            end
        end
    end

endmodule

// File: rtl/vlp_parser.sv
module vlp_parser
    import vlp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [5:0]  out_opcode,
    output logic [1:0]  out_len_code,
    output logic [4:0]  out_rd,
    output logic [4:0]  out_rs1,
    output logic [4:0]  out_src2,
    output logic        out_imm_sel,
    output logic [7:0]  out_invert,
    output logic        out_upd,
    output logic [4:0]  out_pred,
    output logic [9:0]  out_spare,
    output logic [31:0] out_imm,
    output logic [3:0]  out_nbytes
);

    vlp_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    ilen_q;
    logic [TRAIL_W-1:0]  imm_cnt_q;
    logic [TRAIL_W-1:0]  imm_need_q;

    logic                take;
    logic                release_rec;
    logic                clr;
    logic [CNT_W-1:0]    len_now;
    logic [7:0]          b2_now;
    logic                insn_last;
    logic [TRAIL_W-1:0]  trail_now;

    logic [MAX_INSN-1:0][7:0] ib;
    logic [IMM_KEEP-1:0][7:0] tb;
    logic [IMM_W-1:0]         imm_w;
    vlp_rec_t                 rec;

    assign in_ready    = (state_q != S_HOLD);
    assign out_valid   = (state_q == S_HOLD);
    assign take        = in_valid && in_ready;
    assign release_rec = out_valid && out_ready;
    assign clr         = flush || release_rec;

    assign len_now   = (cnt_q == '0) ? insn_bytes(in_data[7:6]) : ilen_q;
    assign b2_now    = (cnt_q == CNT_W'(2)) ? in_data : ib[2];
    assign insn_last = (cnt_q == len_now - CNT_W'(1));
    assign trail_now = trail_count(b2_now);

    vlp_byte_gather #(.DEPTH(MAX_INSN)) u_insn_bytes (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .we  (take && state_q == S_INSN),
        .idx (cnt_q),
        .din (in_data),
        .q   (ib)
    );

    vlp_byte_gather #(.DEPTH(IMM_KEEP)) u_imm_bytes (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .we  (take && state_q == S_IMM && imm_cnt_q < TRAIL_W'(IMM_KEEP)),
        .idx (imm_cnt_q[$clog2(IMM_KEEP)-1:0]),
        .din (in_data),
        .q   (tb)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state_q    <= S_INSN;
            cnt_q      <= '0;
            ilen_q     <= '0;
            imm_cnt_q  <= '0;
            imm_need_q <= '0;
        end else begin
            case (state_q)
                S_INSN: if (take) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == '0)
                        ilen_q <= len_now;
                    if (insn_last) begin
                        imm_need_q <= trail_now;
                        state_q    <= (trail_now == '0) ? S_HOLD : S_IMM;
                    end
                end
                S_IMM: if (take) begin
                    imm_cnt_q <= imm_cnt_q + TRAIL_W'(1);
                    if (imm_cnt_q + TRAIL_W'(1) == imm_need_q)
                        state_q <= S_HOLD;
                end
                S_HOLD: if (out_ready) begin
                    state_q    <= S_INSN;
                    cnt_q      <= '0;
                    ilen_q     <= '0;
                    imm_cnt_q  <= '0;
                    imm_need_q <= '0;
                end
                default: state_q <= S_INSN;
            endcase
        end
    end

    vlp_imm_unit u_imm (
        .imm_sel (ib[2][7]),
        .field   (ib[2][6:2]),
        .tb      (tb),
        .imm     (imm_w)
    );

    always_comb begin
        rec.opcode   = ib[0][5:0];
        rec.len_code = ib[0][7:6];
        rec.rd       = ib[1][4:0];
        rec.rs1      = {ib[2][1:0], ib[1][7:5]};
        rec.src2     = ib[2][6:2];
        rec.imm_sel  = ib[2][7];
        rec.invert   = ib[3];
        rec.pred     = ib[4][4:0];
        rec.upd      = ib[4][5];
        rec.spare    = {ib[5], ib[4][7:6]};
        rec.imm      = imm_w;
        rec.nbytes   = NBYTES_W'(ilen_q) + NBYTES_W'(imm_need_q);
    end

    assign out_opcode   = rec.opcode;
    assign out_len_code = rec.len_code;
    assign out_rd       = rec.rd;
    assign out_rs1      = rec.rs1;
    assign out_src2     = rec.src2;
    assign out_imm_sel  = rec.imm_sel;
    assign out_invert   = rec.invert;
    assign out_upd      = rec.upd;
    assign out_pred     = rec.pred;
    assign out_spare    = rec.spare;
    assign out_imm      = rec.imm;
    assign out_nbytes   = rec.nbytes;

    // Instruction byte counter stays inside the decoded length.
    assert_insn_count_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_INSN && cnt_q != '0) |-> (cnt_q < ilen_q));

    // Trailing-byte counter never reaches its target while still collecting.
    assert_imm_count_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IMM) |-> (imm_cnt_q < imm_need_q));

    // A short inline constant adds no trailing bytes.
    assert_short_len_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_imm_sel && !out_src2[4])
            |-> (out_nbytes == 4'({2'b00, out_len_code}) + 4'd3));

    // Without the immediate flag the immediate is zero and length is the base.
    assert_noimm_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_imm_sel)
            |-> (out_imm == '0 && out_nbytes == 4'({2'b00, out_len_code}) + 4'd3));

    // Consumed byte count stays in range.
    assert_nbytes_range_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_nbytes >= 4'd3 && out_nbytes <= 4'd14));

    // A held record stays put until taken.
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush)
            |=> (out_valid && $stable(out_imm) && $stable(out_nbytes)
                 && $stable(out_opcode) && $stable(out_src2)));

    // Flush returns to an empty, accepting state.
    assert_flush_clear_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!out_valid && in_ready));

endmodule

// File: tb/tb_vlp_parser.sv
`timescale 1ns/1ps
module tb_vlp_parser;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_data;
    logic        out_valid;
    logic        out_ready;
    logic [5:0]  out_opcode;
    logic [1:0]  out_len_code;
    logic [4:0]  out_rd, out_rs1, out_src2, out_pred;
    logic        out_imm_sel, out_upd;
    logic [7:0]  out_invert;
    logic [9:0]  out_spare;
    logic [31:0] out_imm;
    logic [3:0]  out_nbytes;

    int checks = 0;
    int errors = 0;

    logic [7:0] sb [0:15];
    int         sn;
    logic [31:0] e_imm;
    logic [7:0]  e_inv;
    logic [4:0]  e_pred;
    logic        e_upd;
    logic [9:0]  e_spare;
    int          e_len;

    always #2.5 clk = ~clk;

    vlp_parser dut (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_len_code(out_len_code),
        .out_rd(out_rd), .out_rs1(out_rs1), .out_src2(out_src2),
        .out_imm_sel(out_imm_sel), .out_invert(out_invert),
        .out_upd(out_upd), .out_pred(out_pred), .out_spare(out_spare),
        .out_imm(out_imm), .out_nbytes(out_nbytes)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bench model of the requirements, filling sn and e_*.
    task automatic model();
        int ilen, trail, sh;
        logic [4:0] f;
        logic [7:0] b4, b5;
        logic [31:0] v;
        ilen  = int'(sb[0][7:6]) + 3;
        f     = sb[2][6:2];
        trail = 0;
        if (sb[2][7] && f[4]) trail = f[3] ? int'(f[2:0]) + 1 : 1;
        sn    = ilen + trail;
        e_len = sn;
        e_inv = (ilen > 3) ? sb[3] : 8'h00;
        b4    = (ilen > 4) ? sb[4] : 8'h00;
        b5    = (ilen > 5) ? sb[5] : 8'h00;
        e_pred  = b4[4:0];
        e_upd   = b4[5];
        e_spare = {b5, b4[7:6]};
        if (!sb[2][7])      v = 32'h0;
        else if (!f[4])     v = {28'h0, f[3:0]};
        else if (!f[3])     v = {{21{f[2]}}, f[2:0], sb[ilen]};
        else begin
            v = 32'h0;
            for (int k = 0; k < 4; k++)
                if (k < trail) v = v | (32'(sb[ilen+k]) << (8*k));
            if (trail < 4) begin
                sh = 32 - 8*trail;
                v  = $unsigned($signed(v << sh) >>> sh);
            end
        end
        e_imm = v;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain(input int hold);
        @(negedge clk);
        check("R9 out_valid", 32'(out_valid), 32'd1);
        check("R2 opcode", 32'(out_opcode), 32'(sb[0][5:0]));
        check("R2 len_code", 32'(out_len_code), 32'(sb[0][7:6]));
        check("R3 rd", 32'(out_rd), 32'(sb[1][4:0]));
        check("R3 rs1", 32'(out_rs1), 32'({sb[2][1:0], sb[1][7:5]}));
        check("R3 src2", 32'(out_src2), 32'(sb[2][6:2]));
        check("R3 imm_sel", 32'(out_imm_sel), 32'(sb[2][7]));
        check("R4 invert", 32'(out_invert), 32'(e_inv));
        check("R4 pred", 32'(out_pred), 32'(e_pred));
        check("R4 upd", 32'(out_upd), 32'(e_upd));
        check("R4 spare", 32'(out_spare), 32'(e_spare));
        check("R7 imm", out_imm, e_imm);
        check("R9 nbytes", 32'(out_nbytes), 32'(e_len));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check("R10 held valid", 32'(out_valid), 32'd1);
            check("R10 in_ready low", 32'(in_ready), 32'd0);
            check("R10 held imm", out_imm, e_imm);
            check("R10 held nbytes", 32'(out_nbytes), 32'(e_len));
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    task automatic run(input int hold);
        model();
        for (int i = 0; i < sn; i++) push(sb[i]);
        drain(hold);
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 16; i++) sb[i] = 8'($urandom);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 in_ready after reset", 32'(in_ready), 32'd1);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_lengths();
        for (int c = 0; c < 4; c++) begin
            fill_rand();
            sb[0] = {2'(c), 6'(8'h15 + c)};
            sb[2][7] = 1'b0;          // R8: register operand, no trailing bytes
            run(0);
        end
    endtask

    task automatic t_short_imm();
        for (int c = 0; c < 4; c++) begin
            fill_rand();
            sb[0] = {2'(c), 6'h2a};
            sb[2] = {1'b1, 1'b0, 4'(4'hf - c), sb[2][1:0]};   // R5
            run(0);
        end
    endtask

    task automatic t_imm11();
        for (int c = 0; c < 4; c++) begin
            fill_rand();
            sb[0] = {2'(c), 6'h07};
            sb[2] = {1'b1, 2'b10, (c[0] ? 3'b101 : 3'b011), sb[2][1:0]};  // R6
            run(0);
        end
    endtask

    task automatic t_multi();
        for (int n = 0; n < 8; n++) begin
            fill_rand();
            sb[0] = {2'(n % 4), 6'h31};
            sb[2] = {1'b1, 2'b11, 3'(n), sb[2][1:0]};          // R7
            sb[int'(sb[0][7:6]) + 3 + (n < 3 ? n : 0)] = 8'h80 | 8'(n);  // force negative top
            run(0);
        end
    endtask

    task automatic t_backpressure();
        logic [7:0] keep [0:15];
        int kn;
        fill_rand();
        sb[0] = 8'h40;
        sb[2] = {1'b1, 2'b11, 3'd1, 2'b01};
        model();
        for (int i = 0; i < sn; i++) push(sb[i]);
        for (int i = 0; i < 16; i++) keep[i] = sb[i];
        kn = sn;
        fill_rand();
        sb[0] = 8'hc3;
        sb[2] = {1'b1, 2'b10, 3'd6, 2'b10};
        @(negedge clk);
        in_valid = 1'b1;            // R10: next byte offered while held
        in_data  = sb[0];
        for (int i = 0; i < 16; i++) begin logic [7:0] t; t = sb[i]; sb[i] = keep[i]; keep[i] = t; end
        model();
        drain(3);
        for (int i = 0; i < 16; i++) sb[i] = keep[i];
        model();
        for (int i = 0; i < sn; i++) push(sb[i]);
        drain(1);
        check("R10 byte count kept", 32'(kn), 32'd6);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
        @(negedge clk);
        check("R11 in_ready after flush", 32'(in_ready), 32'd1);
        check("R11 out_valid after flush", 32'(out_valid), 32'd0);
    endtask

    task automatic t_flush();
        push(8'hc0); push(8'h11);            // partial instruction
        do_flush();
        fill_rand(); sb[0] = 8'h05; sb[2][7] = 1'b0; run(0);
        push(8'h00); push(8'h22); push({1'b1, 2'b11, 3'd7, 2'b00}); push(8'h99);  // in trailing phase
        do_flush();
        fill_rand(); sb[0] = 8'h46; sb[2] = {1'b1, 2'b10, 3'd2, 2'b11}; run(0);
        fill_rand(); sb[0] = 8'h80; sb[2][7] = 1'b0;
        model();
        for (int i = 0; i < sn; i++) push(sb[i]);
        do_flush();                           // pending record dropped
        fill_rand(); sb[0] = 8'hfe; sb[2] = {1'b1, 2'b11, 3'd3, 2'b01}; run(0);
    endtask

    task automatic t_random();
        for (int r = 0; r < 150; r++) begin
            fill_rand();
            run(int'($urandom_range(0, 3)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; flush = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_lengths();
        t_short_imm();
        t_imm11();
        t_multi();
        t_backpressure();
        t_flush();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule